// File: doc/BRIEF.md
# DRAM Page-Mode Address Controller

This block sits between the memory request path and a DRAM array. It takes a quad-word-aligned byte address (bits 26 down to 3), derives the bank index and the row and column words, and drives them onto a shared multiplexed address bus. The block remembers one open row per bank. From that record it decides whether an access is a page hit, which needs only a column command. A page miss needs a precharge, an activate and then the column command. An access to a closed bank needs an activate and the column command.

The block issues one command per cycle on a strobe with a command code and a row/column phase flag. It accepts a new request only when the previous command sequence has finished. Between requests a page-retention policy decides whether open pages are closed. One setting keeps pages open until a miss forces a precharge. The other closes pages as soon as the host bus is idle and the PCI side does not own the bus.

The device-size selector picks which address bits feed four of the column-phase lines. A wide-address enable turns on the two upper address lines and the second bank select, which 64-Mbit SDRAM devices need. Both are configuration inputs and are treated as static between resets.

Top module: `dram_page_ctl`

## Requirements
- R1: After reset, `req_ready_o` is 1, `cmd_valid_o` is 0, and every bank is closed, so the first request to any bank starts with an activate.
- R2: A row-phase word is {A24, A23, A11, A22, A21..A12}, from bit 13 down to bit 0. Activates drive it with `col_phase_o` = 0.
- R3: A column-phase word has A23 on bit 13, `init_mode_i` on bit 10 and A10..A3 on bits 7..0. It is driven with `col_phase_o` = 1.
- R4: Column bits 12, 11, 9 and 8 are selected by `dev_size_i` (s):
  - bit 12 is A26 when s=0 and A11 otherwise.
  - bit 11 is A11 when s=0 and A25 otherwise.
  - bit 9 is A11, A24 or A26 for s=0, s=1 or s>=2.
  - bit 8 is A11, A22, A23 or A25 for s=0, 1, 2 or 3.
- R5: When `wide_ma_i` is 0, MA bits 13:12 and `ba_o[1]` are 0, and the bank is A11 alone. When `wide_ma_i` is 1, the bank is {A23, A11}. Rows are compared on the masked word.
- R6: A request whose row matches the open row of its bank produces exactly one command: a column command with code 3 (read) or 4 (write), chosen by `req_write_i`.
- R7: A request to an open bank with a different row produces three commands: precharge (code 1) carrying the old row word, then activate (code 2) carrying the new row, then the column command. The new row becomes the bank's open row.
- R8: A request to a closed bank produces an activate and then the column command, and opens that bank.
- R9: With `keep_open_i` = 1, idle cycles issue no command, whatever the state of the bus-activity inputs.
- R10: With `keep_open_i` = 0, `host_idle_i` = 1 and `pci_owns_i` = 0, idle cycles close the open banks. Each close is one precharge carrying that bank's row, the lowest-numbered open bank goes first, and closes come every second cycle. A closed bank then needs an activate.
- R11: With `keep_open_i` = 0, no page is closed while `host_idle_i` is 0 or `pci_owns_i` is 1.
- R12: A request is taken only while `req_ready_o` is 1. The first command appears in the cycle after acceptance. `ba_o` holds the request's bank through the sequence. `req_ready_o` returns in the cycle after the last command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| req_addr_i | input | 24 | Byte address bits 26..3 |
| req_write_i | input | 1 | 1 = write column command, 0 = read |
| init_mode_i | input | 1 | SDRAM initialization in progress |
| keep_open_i | input | 1 | 1 = pages stay open until a miss |
| host_idle_i | input | 1 | Host bus has no activity |
| pci_owns_i | input | 1 | PCI side owns the bus |
| dev_size_i | input | 2 | Device-size selector for column bits |
| wide_ma_i | input | 1 | Enables MA bits 13:12 and the second bank select |
| ma_o | output | 14 | Multiplexed memory address |
| ba_o | output | 2 | Bank select |
| cmd_valid_o | output | 1 | Command strobe |
| cmd_o | output | 3 | 1 precharge, 2 activate, 3 read, 4 write |
| col_phase_o | output | 1 | 1 = column word on `ma_o`, 0 = row word |

## Verification
The assertions assume several things about the inputs:
- `init_mode_i`, `dev_size_i` and `wide_ma_i` do not change while the block is out of reset.
- Reset is held for at least one clock edge.
- The bus-activity inputs are sampled only while the block is idle.

The bench changes configuration only with reset asserted. It sweeps every combination of device size, wide mode and init mode. It moves the policy inputs only at falling edges, between requests. Each request stream mixes guaranteed page hits, made by reusing a row with fresh column and high bits, with pseudo-random rows that give both cold and open-bank misses.

// File: rtl/dram_pc_pkg.sv
// Shared constants and command encoding for the DRAM page controller.
// Assumes a fixed 2K-byte page and quad-word-aligned addresses.
package dram_pc_pkg;
    localparam int ADDR_LO   = 3;
    localparam int ADDR_HI   = 26;
    localparam int MA_W      = 14;
    localparam int MA_NARROW = 12;
    localparam int BANK_W    = 2;
    localparam int NBANK     = 1 << BANK_W;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PRE = 3'd1,
        CMD_ACT = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } dram_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_ACT, S_COL, S_CLOSE
    } ctl_state_e;
endpackage

// File: rtl/dram_addr_map.sv
// Combinational address mapper: splits an address into row word, column
// word and bank. Assumes the size selector and wide enable are static.
module dram_addr_map
    import dram_pc_pkg::*;
(
    input  logic [ADDR_HI:ADDR_LO] addr_i,
    input  logic [1:0]             size_sel_i,
    input  logic                   wide_i,
    input  logic                   init_i,
    output logic [MA_W-1:0]        row_ma_o,
    output logic [MA_W-1:0]        col_ma_o,
    output logic [BANK_W-1:0]      bank_o
);
    localparam int HI_W = MA_W - MA_NARROW;

    logic [MA_W-1:0] keep_mask;
    logic            c12, c11, c9, c8;

    // Picks the size-dependent column sources.
    always_comb begin
        c12 = (size_sel_i == 2'd0) ? addr_i[26] : addr_i[11];
        c11 = (size_sel_i == 2'd0) ? addr_i[11] : addr_i[25];
        case (size_sel_i)
            2'd0:    c9 = addr_i[11];
            2'd1:    c9 = addr_i[24];
            default: c9 = addr_i[26];
        endcase
        case (size_sel_i)
            2'd0:    c8 = addr_i[11];
            2'd1:    c8 = addr_i[22];
            2'd2:    c8 = addr_i[23];
            default: c8 = addr_i[25];
        endcase
    end

    // Builds the masked row/column words and the bank index.
    always_comb begin
        keep_mask = wide_i ? {MA_W{1'b1}} : {{HI_W{1'b0}}, {MA_NARROW{1'b1}}};
        row_ma_o  = {addr_i[24], addr_i[23], addr_i[11], addr_i[22:12]} & keep_mask;
        col_ma_o  = {addr_i[23], c12, c11, init_i, c9, c8, addr_i[10:3]} & keep_mask;
        bank_o    = {wide_i & addr_i[23], addr_i[11]};
    end
endmodule

// File: rtl/dram_page_tbl.sv
// Open-page table: one valid flag and one stored row per bank, a lookup
// port, and a finder for the lowest-numbered open bank.
// Assumes set and clear never target the table in the same cycle.
module dram_page_tbl #(
    parameter int NBANK = 4,
    parameter int ROW_W = 14,
    localparam int BW   = $clog2(NBANK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    lk_bank_i,
    input  logic [ROW_W-1:0] lk_row_i,
    output logic             lk_open_o,
    output logic             lk_match_o,
    output logic [ROW_W-1:0] lk_row_o,
    input  logic             set_en_i,
    input  logic [BW-1:0]    set_bank_i,
    input  logic [ROW_W-1:0] set_row_i,
    input  logic             clr_en_i,
    input  logic [BW-1:0]    clr_bank_i,
    output logic             any_open_o,
    output logic [BW-1:0]    first_bank_o,
    output logic [ROW_W-1:0] first_row_o
);
    logic             vld_q [NBANK];
    logic [ROW_W-1:0] row_q [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        // Holds one bank's open flag and open row.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                row_q[g] <= '0;
            end else if (set_en_i && set_bank_i == BW'(g)) begin
                vld_q[g] <= 1'b1;
                row_q[g] <= set_row_i;
            end else if (clr_en_i && clr_bank_i == BW'(g)) begin
                vld_q[g] <= 1'b0;
            end
        end
    end

    // Looks up the requested bank.
    always_comb begin
        lk_open_o  = vld_q[lk_bank_i];
        lk_row_o   = row_q[lk_bank_i];
        lk_match_o = lk_open_o && (row_q[lk_bank_i] == lk_row_i);
    end

    // Finds the lowest-numbered open bank.
    always_comb begin
        any_open_o   = 1'b0;
        first_bank_o = '0;
        first_row_o  = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (vld_q[i]) begin
                any_open_o   = 1'b1;
                first_bank_o = BW'(i);
                first_row_o  = row_q[i];
            end
        end
    end

    assert_set_clr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en_i && clr_en_i));
    assert_clr_only_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |-> vld_q[clr_bank_i]);
endmodule

// File: rtl/dram_page_ctl.sv
// DRAM page-mode address controller top: accepts one request at a time,
// classifies it as hit, miss or cold, and sequences precharge/activate/
// column commands on a multiplexed address bus. Pages are closed between
// requests according to the retention policy inputs.
// Assumes the configuration inputs are static out of reset.
module dram_page_ctl
    import dram_pc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic [ADDR_HI:ADDR_LO] req_addr_i,
    input  logic                   req_write_i,
    input  logic                   init_mode_i,
    input  logic                   keep_open_i,
    input  logic                   host_idle_i,
    input  logic                   pci_owns_i,
    input  logic [1:0]             dev_size_i,
    input  logic                   wide_ma_i,
    output logic [MA_W-1:0]        ma_o,
    output logic [BANK_W-1:0]      ba_o,
    output logic                   cmd_valid_o,
    output logic [2:0]             cmd_o,
    output logic                   col_phase_o
);
    ctl_state_e        state_q, state_d;
    logic [MA_W-1:0]   map_row, map_col, lk_row, first_row;
    logic [BANK_W-1:0] map_bank, first_bank;
    logic              lk_open, lk_match, any_open;
    logic              accept, close_want;
    logic [MA_W-1:0]   q_row, q_col, q_old;
    logic [BANK_W-1:0] q_bank;
    logic              q_wr;
    dram_cmd_e         cmd_d;

    dram_addr_map u_map (
        .addr_i     (req_addr_i),
        .size_sel_i (dev_size_i),
        .wide_i     (wide_ma_i),
        .init_i     (init_mode_i),
        .row_ma_o   (map_row),
        .col_ma_o   (map_col),
        .bank_o     (map_bank)
    );

    dram_page_tbl #(.NBANK(NBANK), .ROW_W(MA_W)) u_tbl (
        .clk          (clk),
        .rst_n        (rst_n),
        .lk_bank_i    (map_bank),
        .lk_row_i     (map_row),
        .lk_open_o    (lk_open),
        .lk_match_o   (lk_match),
        .lk_row_o     (lk_row),
        .set_en_i     (accept && !lk_match),
        .set_bank_i   (map_bank),
        .set_row_i    (map_row),
        .clr_en_i     (close_want),
        .clr_bank_i   (first_bank),
        .any_open_o   (any_open),
        .first_bank_o (first_bank),
        .first_row_o  (first_row)
    );

    // Decides request acceptance and policy-driven closing.
    always_comb begin
        accept     = (state_q == S_IDLE) && req_valid_i;
        close_want = (state_q == S_IDLE) && !req_valid_i && !keep_open_i
                     && host_idle_i && !pci_owns_i && any_open;
    end

    // Computes the next sequencing state.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE: begin
                if (accept)
                    state_d = lk_match ? S_COL : (lk_open ? S_PRE : S_ACT);
                else if (close_want)
                    state_d = S_CLOSE;
            end
            S_PRE:   state_d = S_ACT;
            S_ACT:   state_d = S_COL;
            default: state_d = S_IDLE;
        endcase
    end

    // Registers the state and the captured request or close target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            q_row   <= '0;
            q_col   <= '0;
            q_old   <= '0;
            q_bank  <= '0;
            q_wr    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                q_row  <= map_row;
                q_col  <= map_col;
                q_old  <= lk_row;
                q_bank <= map_bank;
                q_wr   <= req_write_i;
            end else if (close_want) begin
                q_old  <= first_row;
                q_bank <= first_bank;
            end
        end
    end

    // Drives the command, address word and phase from the state.
    always_comb begin
        cmd_d       = CMD_NOP;
        ma_o        = '0;
        col_phase_o = 1'b0;
        case (state_q)
            S_PRE, S_CLOSE: begin cmd_d = CMD_PRE; ma_o = q_old; end
            S_ACT:          begin cmd_d = CMD_ACT; ma_o = q_row; end
            S_COL: begin
                cmd_d       = q_wr ? CMD_WR : CMD_RD;
                ma_o        = q_col;
                col_phase_o = 1'b1;
            end
            default: ;
        endcase
        cmd_o       = cmd_d;
        cmd_valid_o = (state_q != S_IDLE);
        ba_o        = cmd_valid_o ? q_bank : '0;
        req_ready_o = (state_q == S_IDLE);
    end

    assert_act_then_col_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_o == CMD_ACT) |=> (cmd_valid_o && col_phase_o));
    assert_miss_pre_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PRE) |=> (cmd_valid_o && cmd_o == CMD_ACT));
    assert_bank_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready_o && $past(!req_ready_o)) |-> $stable(ba_o));
    assert_init_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && col_phase_o) |-> (ma_o[10] == init_mode_i));
    assert_close_cond_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CLOSE) |-> $past(!keep_open_i && host_idle_i && !pci_owns_i));
    assert_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_ma_i |-> (ma_o[13:12] == 2'b00 && !ba_o[1]));
endmodule

// File: tb/dram_page_ctl_tb.sv
`timescale 1ns/1ps
module dram_page_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [26:3] req_addr = '0;
    logic        init_mode = 1'b0, keep_open = 1'b1, host_idle = 1'b0, pci_owns = 1'b0;
    logic [1:0]  dev_size = 2'd0;
    logic        wide_ma = 1'b0;
    logic        req_ready, cmd_valid, col_phase;
    logic [13:0] ma;
    logic [1:0]  ba;
    logic [2:0]  cmd;

    int n_chk = 0, n_bad = 0;
    logic [13:0] m_row [4];
    logic        m_vld [4];
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    dram_page_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_addr_i(req_addr), .req_write_i(req_write), .init_mode_i(init_mode),
        .keep_open_i(keep_open), .host_idle_i(host_idle), .pci_owns_i(pci_owns),
        .dev_size_i(dev_size), .wide_ma_i(wide_ma), .ma_o(ma), .ba_o(ba),
        .cmd_valid_o(cmd_valid), .cmd_o(cmd), .col_phase_o(col_phase)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] hi_mask();
        return wide_ma ? 14'h3FFF : 14'h0FFF;
    endfunction

    function automatic logic [13:0] exp_row(input logic [26:3] a);
        logic [13:0] r;
        r[13] = a[24]; r[12] = a[23]; r[11] = a[11]; r[10] = a[22];
        for (int k = 0; k < 10; k++) r[k] = a[12 + k];
        return r & hi_mask();
    endfunction

    function automatic logic [13:0] exp_col(input logic [26:3] a);
        logic [13:0] c;
        for (int k = 0; k < 8; k++) c[k] = a[3 + k];
        c[13] = a[23];
        c[10] = init_mode;
        c[12] = (dev_size == 0) ? a[26] : a[11];
        c[11] = (dev_size == 0) ? a[11] : a[25];
        c[9]  = (dev_size == 0) ? a[11] : (dev_size == 1) ? a[24] : a[26];
        c[8]  = (dev_size == 0) ? a[11] : (dev_size == 1) ? a[22] :
                (dev_size == 2) ? a[23] : a[25];
        return c & hi_mask();
    endfunction

    task automatic expect_cmd(input logic [2:0] code, input logic [13:0] w,
                              input logic ph, input logic [1:0] b, input string tag);
        check({tag, " strobe"}, 32'(cmd_valid), 1);
        check({tag, " code"}, 32'(cmd), 32'(code));
        check({tag, " R2 R3 R4 R5 address"}, 32'(ma), 32'(w));
        check({tag, " phase"}, 32'(col_phase), 32'(ph));
        check({tag, " R5 bank"}, 32'(ba), 32'(b));
    endtask

    // Called at a falling edge with the block idle; returns at a falling edge.
    task automatic do_req(input logic [26:3] a, input logic wr);
        logic [1:0]  b;
        logic [13:0] r, c;
        logic [2:0]  cc;
        b  = {wide_ma & a[23], a[11]};
        r  = exp_row(a);
        c  = exp_col(a);
        cc = wr ? 3'd4 : 3'd3;
        check("R12 ready before request", 32'(req_ready), 1);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        if (m_vld[b] && m_row[b] == r) begin
            expect_cmd(cc, c, 1'b1, b, "R6 hit column");
        end else begin
            if (m_vld[b]) begin
                expect_cmd(3'd1, m_row[b], 1'b0, b, "R7 miss precharge");
                @(negedge clk);
                expect_cmd(3'd2, r, 1'b0, b, "R7 miss activate");
            end else begin
                expect_cmd(3'd2, r, 1'b0, b, "R8 cold activate");
            end
            @(negedge clk);
            expect_cmd(cc, c, 1'b1, b, "R7 R8 column");
            m_vld[b] = 1'b1;
            m_row[b] = r;
        end
        @(negedge clk);
        check("R12 ready after sequence", 32'(req_ready), 1);
    endtask

    task automatic quiet(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(tag, 32'(cmd_valid), 0);
        end
    endtask

    task automatic run_requests(input int n);
        logic [26:3] prev;
        prev = '0;
        for (int i = 0; i < n; i++) begin
            logic [26:3] a;
            seed = seed * 32'd1664525 + 32'd1013904223;
            if (i % 2 == 1) begin
                a = prev;
                a[10:3]  = seed[15:8];
                a[26:25] = seed[17:16];
            end else begin
                a = seed[31:8];
                a[21:14] = 8'h00;
            end
            prev = a;
            do_req(a, seed[0]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R12: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int cfg = 0; cfg < 16; cfg++) begin
            @(negedge clk);
            rst_n = 1'b0;
            dev_size  = cfg[1:0];
            wide_ma   = cfg[2];
            init_mode = cfg[3];
            keep_open = cfg[0];
            host_idle = !cfg[0] ? 1'b0 : 1'b1;
            pci_owns  = 1'b0;
            for (int b = 0; b < 4; b++) begin m_vld[b] = 1'b0; m_row[b] = '0; end
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            check("R1 ready after reset", 32'(req_ready), 1);
            check("R1 no command after reset", 32'(cmd_valid), 0);
            run_requests(24);
            // R9: keep-open policy ignores an idle host.
            keep_open = 1'b1; host_idle = 1'b1; pci_owns = 1'b0;
            quiet(3, "R9 keep-open no close");
            // R11: closing is blocked by host activity or PCI ownership.
            keep_open = 1'b0; host_idle = 1'b0; pci_owns = 1'b0;
            quiet(3, "R11 host busy no close");
            host_idle = 1'b1; pci_owns = 1'b1;
            quiet(3, "R11 pci owns no close");
            // R10: closes in ascending bank order, one every second cycle.
            pci_owns = 1'b0;
            for (int b = 0; b < 4; b++) begin
                if (m_vld[b]) begin
                    @(negedge clk);
                    expect_cmd(3'd1, m_row[b], 1'b0, 2'(b), "R10 policy close");
                    m_vld[b] = 1'b0;
                    @(negedge clk);
                    check("R10 gap between closes", 32'(cmd_valid), 0);
                end
            end
            quiet(2, "R10 nothing left to close");
            keep_open = 1'b1; host_idle = 1'b0;
            run_requests(6);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule